// File: doc/BRIEF.md
# Line-Sync Phase-Frequency Detector with Lock Detector

This block is the digital heart of a horizontal line-sync phase-locked loop. It watches two single-bit inputs that are synchronous to the system clock. One is the incoming line sync, with positive pulses. The other is the reference pulse from the line oscillator. The block acts on the rising (leading) edge of each. It produces UP and DOWN requests for an external charge pump. Because it compares edges in a phase-frequency manner, the loop cannot settle on a harmonic or on a wrong frequency.

For each line the block measures the phase error: the number of clock cycles in which exactly one of UP and DOWN is asserted. A lock detector compares this error with a window. It declares lock after a run of good lines and drops lock after a run of bad lines. It also forces the unlocked state when the oscillator keeps running but no sync edge arrives.

The lock state selects the charge-pump current. While unlocked, the pump uses a small catching current, which gives gentle pull-in. While locked, it uses one of two large currents, and a host register bit picks which. The lock flag uses low-means-locked polarity, so a host status read can use it directly.

Top module: `lineSyncPfd`

## Requirements
- R1: While reset is asserted and on the first cycle after it, pumpUp and pumpDown are 0, unlockFlag is 1 and pumpCode is 2'b00.
- R2: A rising edge of syncIn sampled at a clock edge sets pumpUp from the next cycle on. A level that is held high does not set it again after it has cleared.
- R3: A rising edge of refPulse sampled at a clock edge sets pumpDown from the next cycle on.
- R4: Once pumpUp and pumpDown are both 1, both stay 1 for RESET_DLY cycles and then fall to 0 in the same cycle.
- R5: The phase error of a line is the number of cycles in which exactly one of pumpUp and pumpDown is 1. The line is in window when that count is at most WIN_CYC, whichever edge leads.
- R6: In the unlocked state, LOCK_LINES consecutive in-window lines make the block locked. An out-of-window line restarts the count from zero.
- R7: In the locked state, UNLOCK_LINES consecutive out-of-window lines make the block unlocked. An in-window line restarts that count from zero.
- R8: If TIMEOUT_REFS refPulse rising edges arrive with no syncIn rising edge between them, the block becomes unlocked, and one edge fewer leaves it locked. A line whose phase error overflowed while sync was missing counts as out of window.
- R9: unlockFlag is 0 while locked and 1 while unlocked.
- R10: pumpCode is 2'b00 (catching current) while unlocked. While locked it is 2'b10 (high current) when lowPumpSel is 0 and 2'b01 (reduced current) when lowPumpSel is 1. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Line sync, synchronous to clk, positive pulses |
| refPulse | input | 1 | Reference pulse from the line oscillator |
| lowPumpSel | input | 1 | Host bit: 1 selects the reduced locked pump current |
| pumpUp | output | 1 | Charge-pump UP request |
| pumpDown | output | 1 | Charge-pump DOWN request |
| pumpCode | output | 2 | Pump current select: 00 catch, 01 reduced, 10 high |
| unlockFlag | output | 1 | Lock status, low when locked |

## Verification
The main stimulus is a sweep of the sync-to-reference offset from five cycles of reference lead to five cycles of sync lead, including exact coincidence. This checks, cycle by cycle, which of UP and DOWN opens first and when both close together. The window edges at plus and minus three cycles tell in-window lines from out-of-window lines. Runs of good lines broken by one bad line, and runs of bad lines broken by one good line, tell a correct consecutive count from a cumulative one. Reference pulses with no sync, stopped one short of the limit and then at the limit, probe the timeout boundary. Toggling the host bit while locked and while unlocked separates the three pump codes.

// File: rtl/pfdPkg.sv
package pfdPkg;
  // pump current select codes
  localparam logic [1:0] PUMP_CATCH = 2'b00;
  localparam logic [1:0] PUMP_LOW   = 2'b01;
  localparam logic [1:0] PUMP_HIGH  = 2'b10;

  // strobes from the datapath to the lock control
  typedef struct packed {
    logic lineDone;   // UP/DOWN pair just cleared: one line measured
    logic inWindow;   // phase error of that line within the window
    logic timeout;    // too many reference edges without a sync edge
  } pfdEvt_t;
endpackage

// File: rtl/pfdDatapath.sv
module pfdDatapath
  import pfdPkg::*;
#(
  parameter int RESET_DLY    = 2,
  parameter int WIN_CYC      = 3,
  parameter int TIMEOUT_REFS = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    syncIn,
  input  logic    refPulse,
  output logic    pumpUp,
  output logic    pumpDown,
  output pfdEvt_t evt
);
  localparam int DLY_W   = $clog2(RESET_DLY + 1);
  localparam int ERR_MAX = 2 * WIN_CYC + 1;
  localparam int ERR_W   = $clog2(ERR_MAX + 1);
  localparam int TO_W    = $clog2(TIMEOUT_REFS + 1);

  logic syncQ, refQ, upQ, downQ;
  logic [DLY_W-1:0] dlyCnt;
  logic [ERR_W-1:0] errCnt;
  logic [TO_W-1:0]  refCnt;
  logic syncRise, refRise, bothSet, clearPair, refLimit;

  assign syncRise  = syncIn & ~syncQ;
  assign refRise   = refPulse & ~refQ;
  assign bothSet   = upQ & downQ;
  assign clearPair = bothSet && (dlyCnt == DLY_W'(RESET_DLY - 1));
  assign refLimit  = (refCnt == TO_W'(TIMEOUT_REFS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= 1'b0;
      refQ   <= 1'b0;
      upQ    <= 1'b0;
      downQ  <= 1'b0;
      dlyCnt <= '0;
      errCnt <= '0;
      refCnt <= '0;
    end else begin
      syncQ <= syncIn;
      refQ  <= refPulse;
      upQ   <= clearPair ? 1'b0 : (upQ | syncRise);
      downQ <= clearPair ? 1'b0 : (downQ | refRise);
      dlyCnt <= (bothSet && !clearPair) ? dlyCnt + 1'b1 : '0;
      if (clearPair)
        errCnt <= '0;
      else if ((upQ ^ downQ) && (errCnt != ERR_W'(ERR_MAX)))
        errCnt <= errCnt + 1'b1;
      if (syncRise)
        refCnt <= '0;
      else if (refRise)
        refCnt <= refLimit ? '0 : refCnt + 1'b1;
    end
  end

  assign pumpUp       = upQ;
  assign pumpDown     = downQ;
  assign evt.lineDone = clearPair;
  assign evt.inWindow = (errCnt <= ERR_W'(WIN_CYC));
  assign evt.timeout  = refRise && !syncRise && refLimit;
endmodule

// File: rtl/pfdLockCtrl.sv
module pfdLockCtrl
  import pfdPkg::*;
#(
  parameter int LOCK_LINES   = 4,
  parameter int UNLOCK_LINES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  pfdEvt_t    evt,
  input  logic       lowPumpSel,
  output logic [1:0] pumpCode,
  output logic       unlockFlag
);
  localparam int GOOD_W = $clog2(LOCK_LINES + 1);
  localparam int BAD_W  = $clog2(UNLOCK_LINES + 1);

  logic locked;
  logic [GOOD_W-1:0] goodCnt;
  logic [BAD_W-1:0]  badCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked  <= 1'b0;
      goodCnt <= '0;
      badCnt  <= '0;
    end else if (evt.timeout) begin
      locked  <= 1'b0;
      goodCnt <= '0;
      badCnt  <= '0;
    end else if (evt.lineDone) begin
      if (!locked) begin
        if (!evt.inWindow)
          goodCnt <= '0;
        else if (goodCnt == GOOD_W'(LOCK_LINES - 1)) begin
          locked  <= 1'b1;
          goodCnt <= '0;
          badCnt  <= '0;
        end else
          goodCnt <= goodCnt + 1'b1;
      end else begin
        if (evt.inWindow)
          badCnt <= '0;
        else if (badCnt == BAD_W'(UNLOCK_LINES - 1)) begin
          locked  <= 1'b0;
          badCnt  <= '0;
          goodCnt <= '0;
        end else
          badCnt <= badCnt + 1'b1;
      end
    end
  end

  assign unlockFlag = ~locked;
  assign pumpCode   = !locked ? PUMP_CATCH : (lowPumpSel ? PUMP_LOW : PUMP_HIGH);
endmodule

// File: rtl/lineSyncPfd.sv
module lineSyncPfd
  import pfdPkg::*;
#(
  parameter int RESET_DLY    = 2,
  parameter int WIN_CYC      = 3,
  parameter int TIMEOUT_REFS = 4,
  parameter int LOCK_LINES   = 4,
  parameter int UNLOCK_LINES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic       refPulse,
  input  logic       lowPumpSel,
  output logic       pumpUp,
  output logic       pumpDown,
  output logic [1:0] pumpCode,
  output logic       unlockFlag
);
  pfdEvt_t evt;

  pfdDatapath #(
    .RESET_DLY(RESET_DLY), .WIN_CYC(WIN_CYC), .TIMEOUT_REFS(TIMEOUT_REFS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .refPulse(refPulse),
    .pumpUp(pumpUp), .pumpDown(pumpDown), .evt(evt)
  );

  pfdLockCtrl #(
    .LOCK_LINES(LOCK_LINES), .UNLOCK_LINES(UNLOCK_LINES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .evt(evt), .lowPumpSel(lowPumpSel),
    .pumpCode(pumpCode), .unlockFlag(unlockFlag)
  );
endmodule

// File: rtl/lineSyncPfdChecker.sv
module lineSyncPfdChecker (
  input logic       clk,
  input logic       rstN,
  input logic       syncIn,
  input logic       refPulse,
  input logic       lowPumpSel,
  input logic       pumpUp,
  input logic       pumpDown,
  input logic [1:0] pumpCode,
  input logic       unlockFlag
);
  assert_up_from_sync_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pumpUp) |-> $past(syncIn));

  assert_down_from_ref_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pumpDown) |-> $past(refPulse));

  assert_up_falls_with_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pumpUp) |-> $fell(pumpDown));

  assert_down_falls_with_up_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pumpDown) |-> $fell(pumpUp));

  assert_lock_at_line_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(unlockFlag) |-> $past(pumpUp && pumpDown));

  assert_catch_when_unlocked_R10: assert property (@(posedge clk) disable iff (!rstN)
    unlockFlag |-> (pumpCode == 2'b00));

  assert_no_code3_R10: assert property (@(posedge clk) disable iff (!rstN)
    pumpCode != 2'b11);
endmodule

bind lineSyncPfd lineSyncPfdChecker chk_i (
  .clk(clk), .rstN(rstN), .syncIn(syncIn), .refPulse(refPulse),
  .lowPumpSel(lowPumpSel), .pumpUp(pumpUp), .pumpDown(pumpDown),
  .pumpCode(pumpCode), .unlockFlag(unlockFlag)
);

// File: tb/lineSyncPfd_tb_top.sv
module lineSyncPfd_tb_top;
  localparam int RESET_DLY    = 2;
  localparam int WIN_CYC      = 3;
  localparam int TIMEOUT_REFS = 4;
  localparam int LOCK_LINES   = 4;
  localparam int UNLOCK_LINES = 3;
  localparam int LINE_CYC     = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncIn = 1'b0;
  logic refPulse = 1'b0;
  logic lowPumpSel = 1'b0;
  logic pumpUp, pumpDown, unlockFlag;
  logic [1:0] pumpCode;

  int checks = 0;
  int errors = 0;
  // bench model of the lock detector
  bit mLocked = 1'b0;
  int mGood = 0;
  int mBad = 0;

  always #2.5 clk = ~clk;

  lineSyncPfd #(
    .RESET_DLY(RESET_DLY), .WIN_CYC(WIN_CYC), .TIMEOUT_REFS(TIMEOUT_REFS),
    .LOCK_LINES(LOCK_LINES), .UNLOCK_LINES(UNLOCK_LINES)
  ) dut_i (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .refPulse(refPulse),
    .lowPumpSel(lowPumpSel), .pumpUp(pumpUp), .pumpDown(pumpDown),
    .pumpCode(pumpCode), .unlockFlag(unlockFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expCode();
    if (!mLocked) return 0;
    return lowPumpSel ? 1 : 2;
  endfunction

  task automatic checkLock(input string req);
    check({req, " unlockFlag (R9)"}, int'(unlockFlag), mLocked ? 0 : 1);
    check({req, " pumpCode (R10)"}, int'(pumpCode), expCode());
  endtask

  function automatic void modelLine(input bit good);
    if (!mLocked) begin
      if (!good) mGood = 0;
      else if (mGood == LOCK_LINES - 1) begin mLocked = 1'b1; mGood = 0; mBad = 0; end
      else mGood++;
    end else begin
      if (good) mBad = 0;
      else if (mBad == UNLOCK_LINES - 1) begin mLocked = 1'b0; mBad = 0; mGood = 0; end
      else mBad++;
    end
  endfunction

  // one line: d>0 sync leads ref by d cycles, d<0 ref leads by -d
  // starts and ends on a falling clock edge
  task automatic runLine(input int d, input bit stale);
    int sOff = (d >= 0) ? 0 : -d;
    int rOff = (d >= 0) ? d : 0;
    int last = (sOff > rOff) ? sOff : rOff;
    int mag  = (d >= 0) ? d : -d;
    for (int c = 0; c < LINE_CYC; c++) begin
      if (!stale) begin
        // R2 R4: UP from sync edge until the common clear; R3 R4 same for DOWN
        check($sformatf("R2_R4 up d=%0d c=%0d", d, c), int'(pumpUp),
              (c >= sOff + 1 && c < last + 1 + RESET_DLY) ? 1 : 0);
        check($sformatf("R3_R4 down d=%0d c=%0d", d, c), int'(pumpDown),
              (c >= rOff + 1 && c < last + 1 + RESET_DLY) ? 1 : 0);
      end
      syncIn   = (c >= sOff && c < sOff + 2);
      refPulse = (c >= rOff && c < rOff + 2);
      @(negedge clk);
    end
    // R5: window is |d| <= WIN_CYC; overflowed error is out of window (R8)
    modelLine(!stale && mag <= WIN_CYC);
    checkLock($sformatf("R5_R6_R7 line d=%0d", d));
  endtask

  task automatic refOnly();
    for (int c = 0; c < LINE_CYC; c++) begin
      refPulse = (c < 2);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 up in reset", int'(pumpUp), 0);
    check("R1 down in reset", int'(pumpDown), 0);
    check("R1 unlockFlag in reset", int'(unlockFlag), 1);
    check("R1 pumpCode in reset", int'(pumpCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 up after reset", int'(pumpUp), 0);
    check("R1 unlockFlag after reset", int'(unlockFlag), 1);

    // offset sweep: -5,-4 bad, -3..3 good (locks), 4,5 bad
    for (int d = -5; d <= 5; d++) runLine(d, 1'b0);
    // R7: an in-window line restarts the bad count
    runLine(0, 1'b0);
    runLine(5, 1'b0);
    runLine(-4, 1'b0);
    check("R7 still locked after two bad", int'(unlockFlag), 0);
    runLine(6, 1'b0);
    check("R7 unlocked after three bad", int'(unlockFlag), 1);

    // R6: a bad line restarts the good count
    for (int i = 0; i < LOCK_LINES - 1; i++) runLine(3, 1'b0);
    runLine(-6, 1'b0);
    for (int i = 0; i < LOCK_LINES - 1; i++) runLine(-3, 1'b0);
    check("R6 not locked after broken run", int'(unlockFlag), 1);
    lowPumpSel = 1'b1;
    @(negedge clk);
    check("R10 catch code ignores host bit", int'(pumpCode), 0);
    runLine(-1, 1'b0);
    check("R6 locked after full run", int'(unlockFlag), 0);
    check("R10 reduced current code", int'(pumpCode), 1);
    lowPumpSel = 1'b0;
    @(negedge clk);
    check("R10 high current code", int'(pumpCode), 2);

    // R8: reference without sync
    runLine(-2, 1'b0);
    for (int i = 0; i < TIMEOUT_REFS - 1; i++) refOnly();
    check("R8 locked one edge short", int'(unlockFlag), 0);
    refOnly();
    mLocked = 1'b0; mGood = 0; mBad = 0;
    check("R8 unlocked at limit", int'(unlockFlag), 1);
    check("R8 catch code after timeout", int'(pumpCode), 0);
    runLine(-1, 1'b1);
    check("R8 stale line not counted", int'(unlockFlag), 1);
    for (int i = 0; i < LOCK_LINES; i++) runLine(1, 1'b0);
    check("R6 relock after timeout", int'(unlockFlag), 0);

    // R2: held-high sync is not a new edge
    for (int c = 0; c < LINE_CYC; c++) begin
      syncIn = 1'b1;
      refPulse = (c == 1);
      @(negedge clk);
    end
    check("R2 held sync no new UP", int'(pumpUp), 0);
    check("R3 held sync no stray DOWN", int'(pumpDown), 0);
    syncIn = 1'b0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule